// File: doc/BRIEF.md
# Static Memory Read-Cycle Timing Generator

This block runs read cycles on an external static memory with a 24-bit address bus and an 8-bit data bus. An internal requester offers a chip-select index and an address. The block drives the address, then forms an active-low read strobe and an active-low chip-select strobe. Each strobe has its own setup delay and its own pulse width, counted in clock cycles from the start of the cycle. The block samples the memory data and returns it with a one-clock response pulse.

Every chip select has its own timing set, written through a small register write port. The total cycle length is programmed directly. Neither strobe has a hold value of its own: the time a strobe spends deasserted at the end of the cycle is whatever the cycle length leaves after its setup and pulse. If a setup plus pulse sum is larger than the programmed cycle, the cycle stretches to fit it. When setup and hold are both zero, back-to-back reads keep the strobes asserted without a break.

Top module: `xmem_read_sequencer`

## Requirements
- R1: `mem_addr` takes `req_addr` at the clock edge where `req_valid` and `req_ready` are both high. It keeps that value unchanged until the next accepted request.
- R2: Cycle t=0 is the first clock after the accepting edge. `mem_rd_n` is low exactly in the cycles with rd_setup <= t < rd_setup+rd_pulse. It never goes low when rd_pulse is 0, and it is high while no read runs.
- R3: When the cycle field is at least both setup+pulse sums, a read lasts N = cycle clocks. The read strobe then stays high for N-rd_setup-rd_pulse trailing cycles, and the chip select for N-cs_setup-cs_pulse trailing cycles.
- R4: `mem_cs_n[k]` goes low only for k equal to the accepted `req_cs`, exactly in the cycles with cs_setup <= t < cs_setup+cs_pulse. At no time is more than one chip select low.
- R5: Each chip select keeps its own five timing fields. A write to one chip select leaves the others unchanged, and reads to different chip selects, even back to back, each follow their own fields.
- R6: If rd_setup+rd_pulse or cs_setup+cs_pulse exceeds the cycle field, N becomes the larger of the two sums, and the hold of the longer strobe is zero. If all three values are zero, N is 1.
- R7: `rsp_data` takes `mem_din` on the edge that ends cycle t=rd_setup+rd_pulse-1, which is the last cycle of the read strobe. When rd_pulse is 0 it takes `mem_din` on the edge that ends t=N-1. It holds that value until the next capture.
- R8: `rsp_valid` is high for one clock: the clock right after cycle t=N-1 of each read. At no other time is it high.
- R9: `req_ready` is high while idle and during cycle t=N-1 of a running read. A request accepted in t=N-1 starts its t=0 on the next clock. With zero setup and zero hold, back-to-back reads keep the strobes low with no high cycle in between.
- R10: While `cfg_we` is high at a clock edge, `cfg_field` picks what is written into the set of `cfg_cs`: 0 read setup (low 6 bits of `cfg_wdata`), 1 read pulse, 2 chip-select setup (low 6 bits), 3 chip-select pulse, 4 cycle. Codes 5 to 7 change nothing.
- R11: After reset, `mem_rd_n` and all `mem_cs_n` are high, `rsp_valid` is 0, `req_ready` is 1, and `mem_addr` and `rsp_data` are 0. Every chip select holds read setup 1, read pulse 2, chip-select setup 0, chip-select pulse 4 and cycle 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing is counted in its cycles |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Timing register write enable |
| cfg_cs | input | 2 | Chip select whose timing set is written |
| cfg_field | input | 3 | Field code of the write |
| cfg_wdata | input | 7 | Value written |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | A request is taken at this edge if present |
| req_cs | input | 2 | Chip-select index of the request |
| req_addr | input | 24 | Address of the request |
| rsp_valid | output | 1 | One-clock pulse after each completed read |
| rsp_data | output | 8 | Data sampled from the memory |
| mem_addr | output | 24 | External address bus |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_cs_n | output | 4 | Chip-select strobes, active low |
| mem_din | input | 8 | External data bus |

## Verification
Every strobe level is due in a fixed cycle, counted from the edge that accepted the request. The bench's monitor samples on the falling edge and labels each sample with its cycle index t. From those samples it rebuilds the first-low cycle, the low count and the last-low cycle of every strobe, and it compares them with values the driver computed from its shadow copy of the timing fields. The response is due exactly one clock after the monitor sees the final cycle (ready high while a read runs), and the monitor fails any pulse that comes early, late or unexpected. The memory model returns data that encodes how far into the low phase of the read strobe it was sampled, so the value in `rsp_data` also shows whether the capture happened in the right cycle.

// File: rtl/xmem_rd_pkg.sv
// Shared widths, field codes and record types for the static-memory read
// sequencer. Assumes setup fields narrower than or equal to pulse fields.
package xmem_rd_pkg;

    localparam int SETUP_W = 6;
    localparam int PULSE_W = 7;
    localparam int CYCLE_W = 7;
    localparam int SUM_W   = ((SETUP_W > PULSE_W) ? SETUP_W : PULSE_W) + 1;
    localparam int SPAN_W  = (SUM_W > CYCLE_W) ? SUM_W : CYCLE_W;
    localparam int WIDE_W  = (PULSE_W > CYCLE_W) ? PULSE_W : CYCLE_W;
    localparam int WDATA_W = (WIDE_W > SETUP_W) ? WIDE_W : SETUP_W;
    localparam int FIELD_W = 3;

    typedef enum logic [FIELD_W-1:0] {
        FLD_RD_SETUP = 3'd0,
        FLD_RD_PULSE = 3'd1,
        FLD_CS_SETUP = 3'd2,
        FLD_CS_PULSE = 3'd3,
        FLD_CYCLE    = 3'd4
    } fld_e;

    typedef struct packed {
        logic [SETUP_W-1:0] rd_setup;
        logic [PULSE_W-1:0] rd_pulse;
        logic [SETUP_W-1:0] cs_setup;
        logic [PULSE_W-1:0] cs_pulse;
        logic [CYCLE_W-1:0] cycle;
    } cs_timing_t;

    localparam cs_timing_t TIMING_RST = '{
        rd_setup: SETUP_W'(1),
        rd_pulse: PULSE_W'(2),
        cs_setup: SETUP_W'(0),
        cs_pulse: PULSE_W'(4),
        cycle:    CYCLE_W'(4)
    };

    // Cycle-relative window edges and end points of one read.
    typedef struct packed {
        logic [SPAN_W-1:0] rd_on;
        logic [SPAN_W-1:0] rd_off;
        logic [SPAN_W-1:0] cs_on;
        logic [SPAN_W-1:0] cs_off;
        logic [SPAN_W-1:0] last;
        logic [SPAN_W-1:0] cap;
    } cyc_plan_t;

endpackage

// File: rtl/xmem_rd_cfg.sv
// Timing register bank: one set of five fields per chip select.
// Assumes writes use the field codes from xmem_rd_pkg; other codes are dropped.
module xmem_rd_cfg
    import xmem_rd_pkg::*;
#(
    parameter int  NUM_CS = 4,
    localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [CS_W-1:0]              cfg_cs,
    input  logic [FIELD_W-1:0]           cfg_field,
    input  logic [WDATA_W-1:0]           cfg_wdata,
    output cs_timing_t [NUM_CS-1:0]      timing
);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_set
        cs_timing_t entry_q;
        logic       hit;

        assign hit       = cfg_we && (cfg_cs == CS_W'(g));
        assign timing[g] = entry_q;

        // Load the addressed field of this chip select's timing set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q <= TIMING_RST;
            end else if (hit) begin
                case (cfg_field)
                    FLD_RD_SETUP: entry_q.rd_setup <= cfg_wdata[SETUP_W-1:0];
                    FLD_RD_PULSE: entry_q.rd_pulse <= cfg_wdata[PULSE_W-1:0];
                    FLD_CS_SETUP: entry_q.cs_setup <= cfg_wdata[SETUP_W-1:0];
                    FLD_CS_PULSE: entry_q.cs_pulse <= cfg_wdata[PULSE_W-1:0];
                    FLD_CYCLE:    entry_q.cycle    <= cfg_wdata[CYCLE_W-1:0];
                    default:      entry_q <= entry_q;
                endcase
            end
        end
    end

endmodule

// File: rtl/xmem_rd_plan.sv
// Turns one timing set into window edges for a read: strobe on/off counts,
// the last cycle index (which implies both hold times) and the capture index.
// Pure combinational; assumes the result is registered by the caller.
module xmem_rd_plan
    import xmem_rd_pkg::*;
(
    input  cs_timing_t timing,
    output cyc_plan_t  plan
);

    logic [SPAN_W-1:0] rd_span;
    logic [SPAN_W-1:0] cs_span;
    logic [SPAN_W-1:0] longest;
    logic [SPAN_W-1:0] n_eff;

    // Stretch the cycle to the longest strobe span; never shorter than one clock.
    always_comb begin
        rd_span = SPAN_W'(timing.rd_setup) + SPAN_W'(timing.rd_pulse);
        cs_span = SPAN_W'(timing.cs_setup) + SPAN_W'(timing.cs_pulse);
        longest = SPAN_W'(timing.cycle);
        if (rd_span > longest) longest = rd_span;
        if (cs_span > longest) longest = cs_span;
        n_eff = (longest == '0) ? SPAN_W'(1) : longest;
    end

    // Window edges; hold of each strobe is whatever remains up to 'last'.
    always_comb begin
        plan.rd_on  = SPAN_W'(timing.rd_setup);
        plan.rd_off = rd_span;
        plan.cs_on  = SPAN_W'(timing.cs_setup);
        plan.cs_off = cs_span;
        plan.last   = n_eff - SPAN_W'(1);
        plan.cap    = (timing.rd_pulse == '0) ? (n_eff - SPAN_W'(1))
                                              : (rd_span - SPAN_W'(1));
    end

endmodule

// File: rtl/xmem_rd_seq.sv
// Read-cycle sequencer: accepts a request when idle or in the final cycle,
// counts cycles, drives address and active-low strobes, samples data and
// pulses the response one clock after the final cycle.
// Assumes plan_in belongs to req_cs and is valid whenever req_valid is high.
module xmem_rd_seq
    import xmem_rd_pkg::*;
#(
    parameter int  NUM_CS = 4,
    parameter int  ADDR_W = 24,
    parameter int  DATA_W = 8,
    localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [ADDR_W-1:0] req_addr,
    input  cyc_plan_t         plan_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_n,
    output logic [NUM_CS-1:0] mem_cs_n,
    input  logic [DATA_W-1:0] mem_din
);

    logic              busy_q;
    logic [SPAN_W-1:0] cnt_q;
    cyc_plan_t         plan_q;
    logic [CS_W-1:0]   cs_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              ack_q;
    logic              last_now;
    logic              take;
    logic              rd_win;
    logic              cs_win;

    assign last_now  = busy_q && (cnt_q == plan_q.last);
    assign req_ready = !busy_q || last_now;
    assign take      = req_valid && req_ready;

    // Cycle counter and per-read context; a new read may follow with no gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            plan_q <= '0;
            cs_q   <= '0;
            addr_q <= '0;
        end else if (take) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            plan_q <= plan_in;
            cs_q   <= req_cs;
            addr_q <= req_addr;
        end else if (last_now) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q + SPAN_W'(1);
        end
    end

    // Sample the data bus at the end of the planned capture cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (busy_q && (cnt_q == plan_q.cap)) begin
            data_q <= mem_din;
        end
    end

    // One-clock response after the final cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
        end else begin
            ack_q <= last_now;
        end
    end

    // Strobe windows relative to the cycle start.
    always_comb begin
        rd_win = busy_q && (cnt_q >= plan_q.rd_on) && (cnt_q < plan_q.rd_off);
        cs_win = busy_q && (cnt_q >= plan_q.cs_on) && (cnt_q < plan_q.cs_off);
    end

    for (genvar k = 0; k < NUM_CS; k++) begin : g_csn
        assign mem_cs_n[k] = !(cs_win && (cs_q == CS_W'(k)));
    end

    assign mem_rd_n  = !rd_win;
    assign mem_addr  = addr_q;
    assign rsp_data  = data_q;
    assign rsp_valid = ack_q;

endmodule

// File: rtl/xmem_read_sequencer.sv
// Top of the static-memory read-cycle generator: timing bank, per-request
// plan derivation and the sequencer. Assumes a single clock and that
// req_cs/req_addr are stable while req_valid is high.
module xmem_read_sequencer
    import xmem_rd_pkg::*;
#(
    parameter int  NUM_CS = 4,
    parameter int  ADDR_W = 24,
    parameter int  DATA_W = 8,
    localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CS_W-1:0]    cfg_cs,
    input  logic [FIELD_W-1:0] cfg_field,
    input  logic [WDATA_W-1:0] cfg_wdata,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [CS_W-1:0]    req_cs,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_data,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_rd_n,
    output logic [NUM_CS-1:0]  mem_cs_n,
    input  logic [DATA_W-1:0]  mem_din
);

    cs_timing_t [NUM_CS-1:0] bank;
    cs_timing_t              sel_timing;
    cyc_plan_t               sel_plan;

    xmem_rd_cfg #(.NUM_CS(NUM_CS)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_cs    (cfg_cs),
        .cfg_field (cfg_field),
        .cfg_wdata (cfg_wdata),
        .timing    (bank)
    );

    // Pick the timing set of the requesting chip select.
    always_comb begin
        sel_timing = bank[req_cs];
    end

    xmem_rd_plan plan_i (
        .timing (sel_timing),
        .plan   (sel_plan)
    );

    xmem_rd_seq #(
        .NUM_CS (NUM_CS),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_cs    (req_cs),
        .req_addr  (req_addr),
        .plan_in   (sel_plan),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .mem_addr  (mem_addr),
        .mem_rd_n  (mem_rd_n),
        .mem_cs_n  (mem_cs_n),
        .mem_din   (mem_din)
    );

endmodule

// File: rtl/xmem_read_sequencer_chk.sv
// Protocol checker for xmem_read_sequencer, bound to every instance.
// Observes ports plus the sequencer's busy flag, counter and last index.
module xmem_read_sequencer_chk
    import xmem_rd_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd_n,
    input logic [NUM_CS-1:0] mem_cs_n,
    input logic              busy,
    input logic [SPAN_W-1:0] cnt,
    input logic [SPAN_W-1:0] last
);

    assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> $stable(mem_addr));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_rd_n && (&mem_cs_n)));

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= last));

    assert_cs_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    assert_ack_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (cnt == last)) |=> rsp_valid);

    assert_no_stray_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && (cnt == last)) |=> !rsp_valid);

    assert_ready_final_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (cnt != last)) |-> !req_ready);

    assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy || (cnt == last)) |-> req_ready);

endmodule

bind xmem_read_sequencer xmem_read_sequencer_chk #(
    .NUM_CS (NUM_CS),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_rd_n  (mem_rd_n),
    .mem_cs_n  (mem_cs_n),
    .busy      (seq_i.busy_q),
    .cnt       (seq_i.cnt_q),
    .last      (seq_i.plan_q.last)
);

// File: tb/xmem_read_sequencer_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected read outcomes from a shadow
// timing model; the monitor rebuilds each read's strobe profile on falling
// edges and compares it when the response pulse arrives.
module xmem_read_sequencer_tb_top;

    localparam int NCS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_cs = '0;
    logic [2:0]  cfg_field = '0;
    logic [6:0]  cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_cs = '0;
    logic [23:0] req_addr = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic [23:0] mem_addr;
    logic        mem_rd_n;
    logic [3:0]  mem_cs_n;
    logic [7:0]  mem_din = 8'hA5;

    always #2.5 clk = ~clk;

    xmem_read_sequencer dut_i (
        .clk (clk), .rst_n (rst_n),
        .cfg_we (cfg_we), .cfg_cs (cfg_cs), .cfg_field (cfg_field), .cfg_wdata (cfg_wdata),
        .req_valid (req_valid), .req_ready (req_ready), .req_cs (req_cs), .req_addr (req_addr),
        .rsp_valid (rsp_valid), .rsp_data (rsp_data),
        .mem_addr (mem_addr), .mem_rd_n (mem_rd_n), .mem_cs_n (mem_cs_n), .mem_din (mem_din)
    );

    int n_checks = 0;
    int n_err = 0;
    bit done_run = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_run) begin
            done_run = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    endtask

    // Shadow timing per chip select (R11 reset values).
    int sh_rs[NCS]  = '{1, 1, 1, 1};
    int sh_rp[NCS]  = '{2, 2, 2, 2};
    int sh_css[NCS] = '{0, 0, 0, 0};
    int sh_csp[NCS] = '{4, 4, 4, 4};
    int sh_cyc[NCS] = '{4, 4, 4, 4};

    typedef struct {
        int    cs;
        int    addr;
        int    rs;
        int    rp;
        int    css;
        int    csp;
        int    n;
        int    data;
        string req;
    } exp_t;

    exp_t exp_q[$];

    // Memory model: value = address low byte plus position inside the low phase.
    logic [23:0] mm_prev_addr = '0;
    bit          mm_prev_low = 0;
    int          mm_run = 0;
    always @(negedge clk) begin
        if (!mem_rd_n) begin
            if (mm_prev_low && (mem_addr == mm_prev_addr)) mm_run++;
            else mm_run = 0;
            mem_din = 8'(int'(mem_addr[7:0]) + mm_run);
        end else begin
            mem_din = 8'hA5;
        end
        mm_prev_addr = mem_addr;
        mm_prev_low  = !mem_rd_n;
    end

    // Monitor records: current read and the one just finished.
    bit in_cur = 0;
    bit ack_due = 0;
    int c_tot, c_rf, c_rc, c_rl, c_a0, c_a1;
    int c_cf[NCS], c_cc[NCS], c_cl[NCS];
    int d_tot, d_rf, d_rc, d_rl, d_a0, d_a1;
    int d_cf[NCS], d_cc[NCS], d_cl[NCS];

    task automatic compare(input exp_t e);
        chk(d_tot == e.n, e.req, "cycle length", d_tot, e.n);
        chk(d_a0 == e.addr && d_a1 == e.addr, "R1", "address held", d_a1, e.addr);
        chk(d_rc == e.rp, "R2", "read strobe low count", d_rc, e.rp);
        if (e.rp > 0) begin
            chk(d_rf == e.rs, "R2", "read strobe first low", d_rf, e.rs);
            chk(e.n - 1 - d_rl == e.n - e.rs - e.rp, "R3", "read hold", e.n - 1 - d_rl, e.n - e.rs - e.rp);
        end
        for (int k = 0; k < NCS; k++) begin
            if (k == e.cs) begin
                chk(d_cc[k] == e.csp, "R4", "chip select low count", d_cc[k], e.csp);
                if (e.csp > 0) begin
                    chk(d_cf[k] == e.css, "R4", "chip select first low", d_cf[k], e.css);
                    chk(e.n - 1 - d_cl[k] == e.n - e.css - e.csp, "R3", "chip select hold",
                        e.n - 1 - d_cl[k], e.n - e.css - e.csp);
                end
            end else begin
                chk(d_cc[k] == 0, "R4", "unselected chip select low", d_cc[k], 0);
            end
        end
        chk(int'(rsp_data) == e.data, "R7", "captured data", int'(rsp_data), e.data);
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            // R8: response due exactly one clock after the final cycle.
            if (rsp_valid || ack_due)
                chk(rsp_valid == ack_due, "R8", "response pulse timing", int'(rsp_valid), int'(ack_due));
            if (rsp_valid && ack_due) begin
                if (exp_q.size() == 0) chk(0, "R8", "response without request", 1, 0);
                else compare(exp_q.pop_front());
            end
            ack_due = 0;
            if (in_cur) begin
                if (c_tot == 0) c_a0 = int'(mem_addr);
                c_a1 = int'(mem_addr);
                if (!mem_rd_n) begin
                    if (c_rc == 0) c_rf = c_tot;
                    c_rc++;
                    c_rl = c_tot;
                end
                for (int k = 0; k < NCS; k++) begin
                    if (!mem_cs_n[k]) begin
                        if (c_cc[k] == 0) c_cf[k] = c_tot;
                        c_cc[k]++;
                        c_cl[k] = c_tot;
                    end
                end
                c_tot++;
                if (req_ready) begin
                    d_tot = c_tot; d_rf = c_rf; d_rc = c_rc; d_rl = c_rl; d_a0 = c_a0; d_a1 = c_a1;
                    for (int k = 0; k < NCS; k++) begin
                        d_cf[k] = c_cf[k]; d_cc[k] = c_cc[k]; d_cl[k] = c_cl[k];
                    end
                    in_cur = 0;
                    ack_due = 1;
                end
            end
            if (req_valid && req_ready) begin
                in_cur = 1;
                c_tot = 0; c_rf = -1; c_rc = 0; c_rl = -1; c_a0 = 0; c_a1 = 0;
                for (int k = 0; k < NCS; k++) begin
                    c_cf[k] = -1; c_cc[k] = 0; c_cl[k] = -1;
                end
            end
        end
    end

    // Driver: called just after a rising edge.
    task automatic wr(input int cs, input int fld, input int val);
        cfg_we = 1'b1; cfg_cs = 2'(cs); cfg_field = 3'(fld); cfg_wdata = 7'(val);
        @(posedge clk); #1;
        cfg_we = 1'b0;
        case (fld)
            0: sh_rs[cs]  = val % 64;
            1: sh_rp[cs]  = val;
            2: sh_css[cs] = val % 64;
            3: sh_csp[cs] = val;
            4: sh_cyc[cs] = val;
            default: ;
        endcase
    endtask

    task automatic set_cs(input int cs, input int rs, input int rp, input int css, input int csp, input int cyc);
        wr(cs, 0, rs); wr(cs, 1, rp); wr(cs, 2, css); wr(cs, 3, csp); wr(cs, 4, cyc);
    endtask

    task automatic issue(input int cs, input int addr, input string req);
        exp_t e;
        bit took;
        int n;
        n = sh_cyc[cs];
        if (sh_rs[cs] + sh_rp[cs] > n) n = sh_rs[cs] + sh_rp[cs];
        if (sh_css[cs] + sh_csp[cs] > n) n = sh_css[cs] + sh_csp[cs];
        if (n == 0) n = 1;
        e.cs = cs; e.addr = addr; e.rs = sh_rs[cs]; e.rp = sh_rp[cs];
        e.css = sh_css[cs]; e.csp = sh_csp[cs]; e.n = n; e.req = req;
        e.data = (sh_rp[cs] > 0) ? ((addr + sh_rp[cs] - 1) % 256) : 8'hA5;
        exp_q.push_back(e);
        req_valid = 1'b1; req_cs = 2'(cs); req_addr = 24'(addr);
        forever begin
            took = req_ready;
            @(posedge clk); #1;
            if (took) break;
        end
    endtask

    task automatic drain();
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(posedge clk);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "R8", "watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mem_rd_n == 1'b1, "R11", "reset read strobe", int'(mem_rd_n), 1);
        chk(mem_cs_n == 4'hF, "R11", "reset chip selects", int'(mem_cs_n), 15);
        chk(rsp_valid == 1'b0, "R11", "reset response", int'(rsp_valid), 0);
        chk(req_ready == 1'b1, "R11", "reset ready", int'(req_ready), 1);
        chk(mem_addr == 24'd0, "R11", "reset address", int'(mem_addr), 0);
        chk(rsp_data == 8'd0, "R11", "reset data", int'(rsp_data), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R11 defaults used by a first read on chip select 0.
        issue(0, 24'h000123, "R11");
        drain();

        // R3: cycle longer than both spans, distinct holds.
        set_cs(1, 2, 3, 1, 6, 10);
        issue(1, 24'h0A0B40, "R3");
        drain();

        // R9: zero setup and hold, back to back on one chip select.
        set_cs(2, 0, 5, 0, 5, 5);
        issue(2, 24'h100010, "R9");
        issue(2, 24'h100020, "R9");
        issue(2, 24'h100030, "R9");
        drain();

        // R6: spans exceed the cycle field.
        set_cs(3, 4, 6, 3, 2, 3);
        issue(3, 24'h3300F0, "R6");
        drain();

        // R7: zero read pulse, data taken at the final cycle.
        set_cs(3, 3, 0, 0, 2, 6);
        issue(3, 24'h330011, "R7");
        drain();

        // R6: all zero except one-cycle pulses, one-clock reads back to back.
        set_cs(2, 0, 1, 0, 1, 0);
        issue(2, 24'h200001, "R6");
        issue(2, 24'h200002, "R6");
        issue(2, 24'h200003, "R6");
        drain();

        // R10: unused field codes leave chip select 1 unchanged.
        wr(1, 5, 0);
        wr(1, 7, 127);
        issue(1, 24'h0A0B50, "R10");
        drain();

        // R5: back-to-back reads alternating chip selects with their own timing.
        issue(1, 24'h0C0001, "R5");
        issue(2, 24'h0C0002, "R5");
        issue(0, 24'h0C0003, "R5");
        issue(1, 24'h0C0004, "R5");
        drain();

        // R6: widest fields, 190-cycle read.
        set_cs(3, 63, 127, 63, 127, 127);
        issue(3, 24'hFFFF00, "R6");
        drain();

        chk(exp_q.size() == 0, "R8", "outstanding responses", exp_q.size(), 0);
        finish_run();
    end

endmodule